// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block accumulates a per-cycle event count into a wide running total. On every clock the event source presents a small number: how many events happened in that cycle. The counter adds that number, or adds one, only on cycles where the number passes a programmable comparison against a threshold. This lets software count, for example, only the cycles with a burst of at least N events, or only the cycles with fewer than N. The number of such cycles can be counted instead of the events themselves.

The configuration has three fields. The first is a 12-bit threshold level. The second is a 2-bit compare function. The third is a unit-step bit that selects adding one instead of the event count. The configuration is loaded through a single write strobe. A threshold level of zero switches qualification off, and the counter then adds the raw event count every cycle. A constant capability output reports the largest threshold level this instance accepts, and a value of zero there means qualification is not available. A write that asks for a larger level is rejected. The previous configuration stays in force and an error flag is raised. The counter wraps modulo its width and sets a sticky overflow flag when it does.

Top module: `evt_thresh_counter`

## Requirements
- R1: After synchronous reset the total is 0, the overflow and error flags are 0, and the threshold level is 0, so qualification is off.
- R2: While the stored threshold level is 0, each cycle adds that cycle's raw event count, whatever the compare function and the unit-step bit hold. A cycle with an event count of 0 adds nothing.
- R3: The compare function code selects how the event count E is tested against the level T: code 0 tests E != T, code 1 tests E == T, code 2 tests E >= T and code 3 tests E < T.
- R4: With a nonzero level, the unit-step bit at 0, and the test true, the cycle adds E.
- R5: With a nonzero level, the unit-step bit at 1, and the test true, the cycle adds exactly 1.
- R6: With a nonzero level and the test false, the total does not change.
- R7: The capability output equals the parameter THR_MAX, which is at most 4095. A value of 0 means that every nonzero level is refused.
- R8: A write whose level exceeds the capability is ignored, and the error flag is 1 from the next cycle. An accepted write sets the error flag back to 0.
- R9: A configuration write takes effect from the cycle after the strobe. The event count presented in the strobe cycle is judged by the old configuration.
- R10: The total wraps modulo 2^CNT_W. The overflow flag becomes 1 on the first carry out and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cnt | input | EVW | Number of events in the current cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_level | input | 12 | Threshold level to write |
| cfg_func | input | 2 | Compare function code to write |
| cfg_unit | input | 1 | Unit-step bit to write |
| cap_max | output | 12 | Largest accepted threshold level |
| cfg_err | output | 1 | Last write was rejected |
| total | output | CNT_W | Accumulated count |
| ovf | output | 1 | Sticky wrap indicator |

## Verification
The bench builds the block with CNT_W=16, EVW=8 and THR_MAX=200. The narrow total lets a run of maximum event counts wrap within a few hundred cycles, which exercises the carry and the sticky overflow flag. An 8-bit event count spans values on both sides of many threshold levels, so every compare function meets its below, equal and above cases. A capability of 200 places the accept/reject boundary between 200 and 201, well inside the 12-bit field, and random writes cross it often.

// File: rtl/thr_cnt_pkg.sv
package thr_cnt_pkg;

    localparam int THR_W     = 12;
    localparam int THR_LIMIT = (1 << THR_W) - 1;
    localparam int FUNC_W    = 2;

    typedef enum logic [FUNC_W-1:0] {
        CMP_NE = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_e;

    typedef struct packed {
        logic [THR_W-1:0] level;
        cmp_e             func;
        logic             unit;
    } thr_cfg_t;

    localparam thr_cfg_t CFG_RESET = '{level: '0, func: CMP_NE, unit: 1'b0};

    // Compare a widened event count against a widened level.
    function automatic logic cmp_hit(input logic [31:0] e, input logic [31:0] t, input cmp_e f);
        logic r;
        unique case (f)
            CMP_NE:  r = (e != t);
            CMP_EQ:  r = (e == t);
            CMP_GE:  r = (e >= t);
            default: r = (e <  t);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
    import thr_cnt_pkg::*;
#(
    parameter int THR_MAX = 255
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  thr_cfg_t wr_cfg,
    output thr_cfg_t cfg_q,
    output logic     err_q
);

    localparam logic [THR_W-1:0] CAP = THR_W'(THR_MAX);

    logic accept;
    assign accept = (wr_cfg.level <= CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else if (we) begin
            if (accept) begin
                cfg_q <= wr_cfg;
                err_q <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    // R8: an oversize write leaves the stored configuration untouched and flags it
    assert_reject_keeps_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        (we && (wr_cfg.level > CAP)) |=> ($stable(cfg_q) && err_q));

    // R8: the stored level never exceeds the capability
    assert_level_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_q.level <= CAP);

endmodule

// File: rtl/thr_qualify.sv
module thr_qualify
    import thr_cnt_pkg::*;
#(
    parameter int EVW   = 8,
    parameter int CNT_W = 64
) (
    input  thr_cfg_t         cfg,
    input  logic [EVW-1:0]   evt,
    output logic [CNT_W-1:0] add
);

    logic        off;
    logic        hit;
    logic [31:0] evt_w;
    logic [31:0] lvl_w;

    assign evt_w = 32'(evt);
    assign lvl_w = 32'(cfg.level);
    assign off   = (cfg.level == '0);
    assign hit   = cmp_hit(evt_w, lvl_w, cfg.func);

    always_comb begin
        if (off) begin
            add = CNT_W'(evt);
        end else if (!hit) begin
            add = '0;
        end else if (cfg.unit) begin
            add = CNT_W'(1);
        end else begin
            add = CNT_W'(evt);
        end
    end

endmodule

// File: rtl/thr_accum.sv
module thr_accum #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] add,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt} + {1'b0, add};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= sum[CNT_W-1:0];
            if (sum[CNT_W]) ovf <= 1'b1;
        end
    end

    // R10: once set, the wrap indicator holds until reset
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
    import thr_cnt_pkg::*;
#(
    parameter int EVW     = 8,
    parameter int CNT_W   = 64,
    parameter int THR_MAX = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [EVW-1:0]     evt_cnt,
    input  logic               cfg_we,
    input  logic [THR_W-1:0]   cfg_level,
    input  logic [FUNC_W-1:0]  cfg_func,
    input  logic               cfg_unit,
    output logic [THR_W-1:0]   cap_max,
    output logic               cfg_err,
    output logic [CNT_W-1:0]   total,
    output logic               ovf
);

    initial begin
        if (THR_MAX < 0 || THR_MAX > THR_LIMIT)
            $error("THR_MAX out of range");
        if (EVW > CNT_W)
            $error("EVW wider than CNT_W");
    end

    thr_cfg_t         wr_cfg;
    thr_cfg_t         cfg_q;
    logic [CNT_W-1:0] add;
    logic [CNT_W-1:0] evt_ext;

    assign wr_cfg  = '{level: cfg_level, func: cmp_e'(cfg_func), unit: cfg_unit};
    assign cap_max = THR_W'(THR_MAX);
    assign evt_ext = CNT_W'(evt_cnt);

    thr_cfg_reg #(.THR_MAX(THR_MAX)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q),
        .err_q  (cfg_err)
    );

    thr_qualify #(.EVW(EVW), .CNT_W(CNT_W)) u_qual (
        .cfg (cfg_q),
        .evt (evt_cnt),
        .add (add)
    );

    thr_accum #(.CNT_W(CNT_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .add (add),
        .cnt (total),
        .ovf (ovf)
    );

    // R2: with qualification off the total advances by the raw event count
    assert_off_adds_raw_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.level == '0) |=> (total == CNT_W'($past(total) + $past(evt_ext))));

    // R5: in unit-step mode the total moves by at most one per cycle
    assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.level != '0) && cfg_q.unit) |=>
            ((total == $past(total)) || (total == CNT_W'($past(total) + 1'b1))));

endmodule

// File: tb/test_evt_thresh_counter.sv
module test_evt_thresh_counter;

    localparam int EVW   = 8;
    localparam int CNT_W = 16;
    localparam int TMAX  = 200;
    localparam int MODV  = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [EVW-1:0]   evt_cnt = '0;
    logic             cfg_we = 1'b0;
    logic [11:0]      cfg_level = '0;
    logic [1:0]       cfg_func = '0;
    logic             cfg_unit = 1'b0;
    logic [11:0]      cap_max;
    logic             cfg_err;
    logic [CNT_W-1:0] total;
    logic             ovf;

    int n_checks = 0;
    int n_fail   = 0;

    int m_lvl = 0, m_func = 0, m_unit = 0;
    int m_cnt = 0, m_ovf = 0, m_err = 0;

    always #10 clk = ~clk;

    evt_thresh_counter #(.EVW(EVW), .CNT_W(CNT_W), .THR_MAX(TMAX)) i_evt_thresh_counter (
        .clk(clk), .rst(rst), .evt_cnt(evt_cnt), .cfg_we(cfg_we),
        .cfg_level(cfg_level), .cfg_func(cfg_func), .cfg_unit(cfg_unit),
        .cap_max(cap_max), .cfg_err(cfg_err), .total(total), .ovf(ovf)
    );

    function automatic bit m_hit(int e, int t, int f);
        case (f)
            0: return e != t;
            1: return e == t;
            2: return e >= t;
            default: return e < t;
        endcase
    endfunction

    function automatic int m_add(int e, int t, int f, int u);
        if (t == 0) return e;
        if (!m_hit(e, t, f)) return 0;
        return (u != 0) ? 1 : e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, sample at the next negedge.
    task automatic step(input int e, input bit we, input int lvl, input int f, input int u,
                        input string req);
        int s;
        evt_cnt   = EVW'(e);
        cfg_we    = we;
        cfg_level = 12'(lvl);
        cfg_func  = 2'(f);
        cfg_unit  = u[0];
        s = m_cnt + m_add(e, m_lvl, m_func, m_unit);
        if (s >= MODV) m_ovf = 1;
        m_cnt = s % MODV;
        if (we) begin
            if (lvl <= TMAX) begin
                m_lvl = lvl; m_func = f; m_unit = u; m_err = 0;
            end else begin
                m_err = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        check(int'(total) == m_cnt, req, int'(total), m_cnt);
        check(int'(ovf) == m_ovf, "R10", int'(ovf), m_ovf);
        check(int'(cfg_err) == m_err, "R8", int'(cfg_err), m_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(total == '0, "R1", int'(total), 0);
        check(ovf == 1'b0, "R1", int'(ovf), 0);
        check(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
        // R7 capability
        check(int'(cap_max) == TMAX, "R7", int'(cap_max), TMAX);
        // R1/R2: qualification off after reset, raw adds, zero adds nothing
        step(3, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, "R2");
        // R2: level 0 with other fields set is still raw
        step(0, 1, 0, 3, 1, "R2");
        step(7, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        // R3/R4/R6: each compare code against level 5
        for (int f = 0; f < 4; f++) begin
            step(0, 1, 5, f, 0, "R9");
            step(4, 0, 0, 0, 0, "R3");
            step(5, 0, 0, 0, 0, "R4");
            step(6, 0, 0, 0, 0, "R6");
        end
        // R5: unit step with greater-or-equal 10
        step(0, 1, 10, 2, 1, "R9");
        step(200, 0, 0, 0, 0, "R5");
        step(9, 0, 0, 0, 0, "R6");
        step(10, 0, 0, 0, 0, "R5");
        // R9: the strobe cycle uses the old configuration
        step(0, 1, 0, 0, 0, "R9");
        step(9, 1, 20, 1, 0, "R9");
        step(9, 0, 0, 0, 0, "R9");
        step(20, 0, 0, 0, 0, "R4");
        // R8: boundary at the capability, rejected write keeps old config
        step(0, 1, 201, 2, 1, "R8");
        step(20, 0, 0, 0, 0, "R8");
        step(0, 1, 4095, 0, 0, "R8");
        step(21, 0, 0, 0, 0, "R8");
        step(0, 1, 200, 2, 0, "R8");
        step(200, 0, 0, 0, 0, "R8");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit we = ($urandom % 10) == 0;
            int lvl = ($urandom % 4 == 0) ? 0 : int'($urandom % 261);
            step(int'($urandom % 256), we, lvl, int'($urandom % 4), int'($urandom % 2), "R3");
        end
        // R10: wrap with raw counting at maximum event count
        step(0, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 300; i++) step(255, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed = 12345;
        void'($urandom(seed));
    end

endmodule